// File: doc/BRIEF.md
# Two-Wire Bus Master with SMBus Error Handling

This block is a single-command master for a two-wire serial bus (I2C with SMBus extensions). Software loads one command: a 7-bit target address, a direction, a byte count and an optional packet error code (PEC) byte. The block then issues a START and the address byte, moves the requested number of data bytes, and ends with a STOP. Transmit data enters through a one-byte holding register. Receive data leaves through a one-byte holding register with a ready flag. Both bus lines are open-drain: the `*_oe` outputs pull a line low when high, and the `*_i` inputs read the wired level.

Each bus event leaves a sticky flag in an 8-bit status word. Software clears a flag by writing a one to its bit of `stat_clr`. Each error has its own recovery:

- A not-acknowledge ends the transfer with an automatic STOP.
- A clock-low timeout also ends the transfer with an automatic STOP.
- A PEC mismatch on a read also ends the transfer with an automatic STOP.
- A lost arbitration releases both lines at once and generates no STOP.

After any error the command stays marked valid and completion is not reported, so software can inspect the command or retry it. A software stop request is honoured only at the end of the byte in progress.

Top module: `i2c_smb_master`

## Requirements
- R1: While reset is asserted, and just after it, the block holds `status`=0, `cmd_valid`=0 and `busy`=0, and both `scl_oe` and `sda_oe` are 0 (lines released).
- R2: A write command sends, in this order: START; the address byte `{cmd_addr, 0}`; the data bytes taken from the transmit holding register; STOP. Each byte goes out MSB first. `tx_full` is set by `tx_wr` and cleared when the block takes the byte for sending. On a clean finish, status bit 0 (complete) is set and `cmd_valid` drops.
- R3: A read command sends the address byte `{cmd_addr, 1}` and then receives `cmd_len` bytes. Each received byte appears on `rx_data` with `rx_ready` set, and `rx_rd` clears `rx_ready`. The master acknowledges (SDA low) every received byte except the last one on the bus, which it does not acknowledge.
- R4: With `cmd_pec`=1, the PEC is a CRC-8 with polynomial x^8+x^2+x+1 (0x07), initial value 0, MSB first. It covers the address byte and every data byte. In a write, the PEC is sent as one extra byte after the data.
- R5: In a read with `cmd_pec`=1, one extra byte is received and compared with the PEC; this byte is never delivered to `rx_data`. On a match the command completes normally. On a mismatch, status bit 5 is set, a STOP follows, bit 0 stays clear and `cmd_valid` stays 1.
- R6: A not-acknowledged address byte sets status bit 1 and sends STOP with no data byte. Bit 0 stays clear and `cmd_valid` stays 1.
- R7: A not-acknowledged write data byte or write PEC byte sets status bit 2 and sends STOP. Bit 0 stays clear and `cmd_valid` stays 1.
- R8: When SDA reads low while the block is releasing it for a 1 bit of the address or write data, status bit 3 is set. In the same cycle `scl_oe`=0, `sda_oe`=0 and `busy`=0. No STOP is generated, and `cmd_valid` stays 1.
- R9: If SCL stays low for `TMO_CYC` consecutive cycles during START or a byte, status bit 4 is set. A STOP follows once SCL is released. Bit 0 stays clear and `cmd_valid` stays 1.
- R10: A `stop_req` pulse during a transfer lets the current byte finish. A STOP follows and no further byte is sent. Then status bits 6 and 0 are set and `cmd_valid` stays 1.
- R11: `smb_alert_n` low sets status bit 7. It has no effect on the transfer, which completes normally.
- R12: A one in bit k of `stat_clr` clears status bit k only; all other bits keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Load command and start (ignored while busy) |
| cmd_addr | input | 7 | Target address |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_len | input | NBW | Number of data bytes |
| cmd_pec | input | 1 | Append or check PEC byte |
| cmd_valid | output | 1 | Command valid bit |
| busy | output | 1 | Transfer in progress |
| tx_wr | input | 1 | Write transmit holding register |
| tx_data | input | 8 | Transmit byte |
| tx_full | output | 1 | Transmit holding register occupied |
| rx_rd | input | 1 | Acknowledge read of receive holding register |
| rx_data | output | 8 | Received byte |
| rx_ready | output | 1 | Receive holding register holds a new byte |
| stop_req | input | 1 | Software stop request strobe |
| stat_clr | input | 8 | Write-one-to-clear strobes for status |
| status | output | 8 | Bit0 complete, 1 addr-NACK, 2 data-NACK, 3 arbitration lost, 4 timeout, 5 PEC error, 6 stopped, 7 alert |
| smb_alert_n | input | 1 | SMBus alert line, active low |
| scl_i | input | 1 | SCL level on the bus |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_i | input | 1 | SDA level on the bus |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
A wrong bit counter or byte counter shows on the bus within one byte time: a frame comes out with the wrong length, or an extra or missing frame appears before STOP. These are caught by the frame scoreboard, which also checks each acknowledge bit. A corrupted CRC register stays hidden until the final byte. It then appears as a wrong PEC byte on writes, or a false PEC error on reads. A wrong record of how the transfer ended appears only at the STOP, as a wrong mix of complete, stop and error bits, or as a wrong `cmd_valid`. Arbitration and timeout faults appear within a quarter bit as lines that are still driven, or as a missing STOP.

// File: rtl/i2c_smb_master.sv
module i2c_smb_master #(
  parameter int DIV     = 8,
  parameter int TMO_CYC = 100000,
  parameter int NBW     = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_wr,
  input  logic [6:0]     cmd_addr,
  input  logic           cmd_read,
  input  logic [NBW-1:0] cmd_len,
  input  logic           cmd_pec,
  output logic           cmd_valid,
  output logic           busy,
  input  logic           tx_wr,
  input  logic [7:0]     tx_data,
  output logic           tx_full,
  input  logic           rx_rd,
  output logic [7:0]     rx_data,
  output logic           rx_ready,
  input  logic           stop_req,
  input  logic [7:0]     stat_clr,
  output logic [7:0]     status,
  input  logic           smb_alert_n,
  input  logic           scl_i,
  output logic           scl_oe,
  input  logic           sda_i,
  output logic           sda_oe
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int TW = $clog2(TMO_CYC + 1);
  localparam logic [NBW:0] ONE = 1;
  localparam int F_CMP = 0, F_ANAK = 1, F_DNAK = 2, F_ARB = 3;
  localparam int F_TMO = 4, F_PEC = 5, F_STOP = 6, F_ALR = 7;

  typedef enum logic [1:0] {S_IDLE, S_START, S_BIT, S_STOP} st_t;
  typedef enum logic [1:0] {K_ERR, K_OK, K_REQ} end_t;

  st_t          st;
  end_t         kind;
  logic [CW-1:0] cnt;
  logic [TW-1:0] tcnt;
  logic [1:0]   qc;
  logic [3:0]   bitn;
  logic [7:0]   sh, thr, crc, flags;
  logic [NBW:0] left;
  logic         rd, pec_en, is_addr, is_pec, lastb, stop_pend, nack;

  function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] x;
    x = c ^ d;
    for (int i = 0; i < 8; i++) x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
    return x;
  endfunction

  assign busy   = (st != S_IDLE);
  assign status = flags;

  wire drv   = is_addr || !rd;
  wire tick  = busy && (cnt == CW'(DIV - 1));
  wire stall = (qc == 2'd2) && !scl_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; kind <= K_ERR; cnt <= '0; tcnt <= '0; qc <= '0; bitn <= '0;
      sh <= '0; thr <= '0; crc <= '0; flags <= '0; left <= '0;
      rd <= 1'b0; pec_en <= 1'b0; is_addr <= 1'b0; is_pec <= 1'b0; lastb <= 1'b0;
      stop_pend <= 1'b0; nack <= 1'b0; cmd_valid <= 1'b0; tx_full <= 1'b0;
      rx_data <= '0; rx_ready <= 1'b0; scl_oe <= 1'b0; sda_oe <= 1'b0;
    end else begin
      flags <= flags & ~stat_clr;
      if (tx_wr) begin thr <= tx_data; tx_full <= 1'b1; end
      if (rx_rd) rx_ready <= 1'b0;
      if (!smb_alert_n) flags[F_ALR] <= 1'b1;
      if (stop_req && busy) stop_pend <= 1'b1;
      cnt  <= (busy && cnt != CW'(DIV - 1)) ? cnt + CW'(1) : '0;
      tcnt <= ((st == S_START || st == S_BIT) && !scl_i) ? tcnt + TW'(1) : '0;

      if (st == S_IDLE) begin
        if (cmd_wr) begin
          st <= S_START; cmd_valid <= 1'b1; rd <= cmd_read; pec_en <= cmd_pec;
          left <= {1'b0, cmd_len} + {{NBW{1'b0}}, cmd_pec};
          sh <= {cmd_addr, cmd_read}; crc <= crc8(8'h00, {cmd_addr, cmd_read});
          is_addr <= 1'b1; is_pec <= 1'b0; lastb <= 1'b0; stop_pend <= 1'b0;
          qc <= '0; bitn <= '0; cnt <= '0;
        end
      end else if (st != S_STOP && tcnt == TW'(TMO_CYC - 1)) begin
        flags[F_TMO] <= 1'b1; kind <= K_ERR; st <= S_STOP;
        qc <= '0; cnt <= '0; scl_oe <= 1'b1;
      end else if (tick && !stall) begin
        qc <= qc + 2'd1;
        case (st)
          S_START: begin
            if (qc == 2'd2) sda_oe <= 1'b1;
            if (qc == 2'd3) begin scl_oe <= 1'b1; st <= S_BIT; bitn <= '0; end
          end
          S_BIT: begin
            case (qc)
              2'd0: begin
                if (bitn == 4'd8)
                  sda_oe <= drv ? 1'b0 : !(lastb || stop_pend);
                else if (bitn == 4'd0 && !is_addr && !rd && !is_pec) begin
                  if (tx_full) begin
                    sh <= thr; sda_oe <= !thr[7]; tx_full <= 1'b0; crc <= crc8(crc, thr);
                  end else
                    qc <= 2'd0;
                end else
                  sda_oe <= drv ? !sh[7] : 1'b0;
              end
              2'd1: scl_oe <= 1'b0;
              2'd2: begin
                if (bitn != 4'd8) begin
                  if (drv) begin
                    if (!sda_oe && !sda_i) begin
                      flags[F_ARB] <= 1'b1; st <= S_IDLE; qc <= '0;
                      scl_oe <= 1'b0; sda_oe <= 1'b0;
                    end
                  end else
                    sh <= {sh[6:0], sda_i};
                end else
                  nack <= sda_i;
              end
              default: begin
                scl_oe <= 1'b1;
                if (bitn != 4'd8) begin
                  bitn <= bitn + 4'd1;
                  if (drv) sh <= {sh[6:0], 1'b0};
                end else begin
                  bitn <= '0;
                  if (drv && nack) begin
                    flags[is_addr ? F_ANAK : F_DNAK] <= 1'b1; kind <= K_ERR; st <= S_STOP;
                  end else if (!drv && is_pec && sh != crc) begin
                    flags[F_PEC] <= 1'b1; kind <= K_ERR; st <= S_STOP;
                  end else begin
                    if (!drv && !is_pec) begin
                      rx_data <= sh; rx_ready <= 1'b1; crc <= crc8(crc, sh);
                    end
                    if (stop_pend) begin
                      kind <= K_REQ; st <= S_STOP;
                    end else if (left == '0) begin
                      kind <= K_OK; st <= S_STOP;
                    end else begin
                      left <= left - ONE; is_addr <= 1'b0;
                      is_pec <= pec_en && (left == ONE);
                      lastb <= (left == ONE);
                      if (pec_en && left == ONE && !rd) sh <= crc;
                    end
                  end
                end
              end
            endcase
          end
          S_STOP: begin
            if (qc == 2'd0) sda_oe <= 1'b1;
            if (qc == 2'd1) scl_oe <= 1'b0;
            if (qc == 2'd3) begin
              sda_oe <= 1'b0; st <= S_IDLE;
              if (kind == K_OK) begin flags[F_CMP] <= 1'b1; cmd_valid <= 1'b0; end
              if (kind == K_REQ) begin flags[F_CMP] <= 1'b1; flags[F_STOP] <= 1'b1; end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2
  busy_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cmd_valid);
  // R8
  arb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[F_ARB]) |-> (!scl_oe && !sda_oe && !busy));
  // R2
  cmp_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[F_CMP]) |-> $past(st == S_STOP));
  // R6
  err_keeps_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|flags[5:1]) |-> cmd_valid);
  // R3
  rx_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> rd);
  // R2
  tx_taken_in_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_full) |-> $past(st == S_BIT));
endmodule

// File: tb/test_i2c_smb_master.sv
module test_i2c_smb_master;
  localparam int DIV = 4, TMO = 300, NBW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic cmd_wr = 0, cmd_read = 0, cmd_pec = 0, tx_wr = 0, rx_rd = 0, stop_req = 0;
  logic [6:0] cmd_addr = 0;
  logic [NBW-1:0] cmd_len = 0;
  logic [7:0] tx_data = 0, stat_clr = 0;
  logic smb_alert_n = 1;
  logic cmd_valid, busy, tx_full, rx_ready, scl_oe, sda_oe;
  logic [7:0] rx_data, status;
  logic slv_sda_low = 0, slv_scl_low = 0, oth_sda_low = 0;
  logic scl, sda;
  assign scl = !(scl_oe || slv_scl_low);
  assign sda = !(sda_oe || slv_sda_low || oth_sda_low);

  i2c_smb_master #(.DIV(DIV), .TMO_CYC(TMO), .NBW(NBW)) i_i2c_smb_master (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_read(cmd_read),
    .cmd_len(cmd_len), .cmd_pec(cmd_pec), .cmd_valid(cmd_valid), .busy(busy),
    .tx_wr(tx_wr), .tx_data(tx_data), .tx_full(tx_full), .rx_rd(rx_rd), .rx_data(rx_data),
    .rx_ready(rx_ready), .stop_req(stop_req), .stat_clr(stat_clr), .status(status),
    .smb_alert_n(smb_alert_n), .scl_i(scl), .scl_oe(scl_oe), .sda_i(sda), .sda_oe(sda_oe));

  int checks = 0, fails = 0, stops = 0, bitc = 0, fidx = 0, nak_frame = -1;
  string cur_req = "R2";
  logic [8:0] exp_q[$];
  logic [7:0] rd_bytes[$], wq[$], rq[$];
  logic [7:0] mbyte = 0;
  logic addr_rd = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] bcrc(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      logic fb = r[7] ^ d[i];
      r = {r[6:0], 1'b0};
      if (fb) r = r ^ 8'h07;
    end
    return r;
  endfunction

  // bus monitor and scoreboard
  always @(negedge sda) if (scl === 1'b1) begin bitc = 0; fidx = 0; end
  always @(posedge sda) if (scl === 1'b1) stops++;
  always @(posedge scl) begin
    if (bitc < 8) mbyte = {mbyte[6:0], sda};
    bitc++;
    if (bitc == 9) begin
      bitc = 0;
      if (fidx == 0) addr_rd = mbyte[0];
      if (exp_q.size() == 0) chk(cur_req, "unexpected frame", {23'd0, mbyte, sda}, 32'h1ff);
      else chk(cur_req, "frame", {23'd0, mbyte, sda}, {23'd0, exp_q.pop_front()});
      fidx++;
    end
  end

  // slave model
  always @(negedge scl) begin
    if (bitc == 8) slv_sda_low = (fidx == 0) ? (nak_frame != 0) : (!addr_rd && nak_frame != fidx);
    else if (fidx > 0 && addr_rd && bitc < 8 && fidx - 1 < rd_bytes.size())
      slv_sda_low = !rd_bytes[fidx-1][7-bitc];
    else slv_sda_low = 0;
  end

  task automatic tk(input int n); repeat (n) @(negedge clk); endtask

  task automatic clear_all();
    stat_clr = 8'hFF; tk(1); stat_clr = 0;
    exp_q.delete(); rd_bytes.delete(); nak_frame = -1; tk(2);
  endtask

  task automatic issue(input logic [6:0] a, input logic r, input int n, input logic p);
    cmd_addr = a; cmd_read = r; cmd_len = NBW'(n); cmd_pec = p; cmd_wr = 1; tk(1); cmd_wr = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 30000) begin tk(1); n++; end
    tk(8);
  endtask

  task automatic put_tx(input logic [7:0] d);
    tx_data = d; tx_wr = 1; tk(1); tx_wr = 0;
  endtask

  task automatic run_write(input logic [6:0] a, input logic p, input int nak);
    logic [7:0] c;
    bit done = 0;
    int n = wq.size();
    nak_frame = nak;
    c = bcrc(8'h00, {a, 1'b0});
    exp_q.push_back({a, 1'b0, nak == 0});
    done = (nak == 0);
    for (int i = 0; i < n && !done; i++) begin
      c = bcrc(c, wq[i]);
      exp_q.push_back({wq[i], nak == i + 1});
      done = (nak == i + 1);
    end
    if (p && !done) exp_q.push_back({c, nak == n + 1});
    if (n > 0) put_tx(wq[0]);
    issue(a, 1'b0, n, p);
    for (int i = 1; i < n; i++) begin
      while (tx_full && busy) tk(1);
      if (!busy) break;
      put_tx(wq[i]);
    end
    wait_idle();
  endtask

  task automatic run_read(input logic [6:0] a, input logic p, input logic bad);
    logic [7:0] c;
    int n = rq.size(), tot = rq.size() + (p ? 1 : 0), got = 0;
    c = bcrc(8'h00, {a, 1'b1});
    exp_q.push_back({a, 1'b1, 1'b0});
    for (int i = 0; i < n; i++) begin
      c = bcrc(c, rq[i]);
      exp_q.push_back({rq[i], i == tot - 1});
      rd_bytes.push_back(rq[i]);
    end
    if (p) begin
      rd_bytes.push_back(bad ? (c ^ 8'h5A) : c);
      exp_q.push_back({bad ? (c ^ 8'h5A) : c, 1'b1});
    end
    issue(a, 1'b1, n, p);
    while (busy || rx_ready) begin
      if (rx_ready) begin
        chk("R3", "rx byte", {24'd0, rx_data}, (got < n) ? {24'd0, rq[got]} : 32'hdead);
        got++;
        rx_rd = 1; tk(1); rx_rd = 0;
      end else tk(1);
    end
    chk("R3", "rx byte count", got, n);
    wait_idle();
  endtask

  initial begin
    int s0;
    tk(3);
    chk("R1", "status in reset", {24'd0, status}, 0);
    chk("R1", "lines released", {30'd0, scl_oe, sda_oe}, 0);
    chk("R1", "valid/busy", {30'd0, cmd_valid, busy}, 0);
    rst_n = 1; tk(3);
    chk("R1", "status after reset", {24'd0, status}, 0);

    // R2 R4: write with PEC
    cur_req = "R2/R4"; clear_all(); s0 = stops;
    wq = '{8'hA5, 8'h3C}; run_write(7'h52, 1'b1, -1);
    chk("R2", "frames left", exp_q.size(), 0);
    chk("R2", "status complete", {24'd0, status}, 8'h01);
    chk("R2", "valid cleared", {31'd0, cmd_valid}, 0);
    chk("R2", "tx_full cleared", {31'd0, tx_full}, 0);
    chk("R2", "stop count", stops - s0, 1);

    // R2: plain write, three bytes
    cur_req = "R2"; clear_all();
    wq = '{8'h00, 8'hFF, 8'h81}; run_write(7'h2A, 1'b0, -1);
    chk("R2", "frames left", exp_q.size(), 0);
    chk("R2", "status", {24'd0, status}, 8'h01);

    // R3: read without PEC
    cur_req = "R3"; clear_all();
    rq = '{8'h12, 8'hEF, 8'h80}; run_read(7'h11, 1'b0, 1'b0);
    chk("R3", "frames left", exp_q.size(), 0);
    chk("R3", "status", {24'd0, status}, 8'h01);
    chk("R3", "valid cleared", {31'd0, cmd_valid}, 0);

    // R5: read with good PEC
    cur_req = "R5"; clear_all();
    rq = '{8'h5A, 8'h01}; run_read(7'h33, 1'b1, 1'b0);
    chk("R5", "frames left", exp_q.size(), 0);
    chk("R5", "good pec status", {24'd0, status}, 8'h01);

    // R5: read with bad PEC
    clear_all(); s0 = stops;
    rq = '{8'h77}; run_read(7'h33, 1'b1, 1'b1);
    chk("R5", "frames left", exp_q.size(), 0);
    chk("R5", "pec error status", {24'd0, status}, 8'h20);
    chk("R5", "valid kept", {31'd0, cmd_valid}, 1);
    chk("R5", "stop sent", stops - s0, 1);

    // R6: address NACK
    cur_req = "R6"; clear_all(); s0 = stops;
    wq = '{8'h44}; run_write(7'h0F, 1'b0, 0);
    chk("R6", "frames left", exp_q.size(), 0);
    chk("R6", "anak status", {24'd0, status}, 8'h02);
    chk("R6", "valid kept", {31'd0, cmd_valid}, 1);
    chk("R6", "stop sent", stops - s0, 1);

    // R7: data NACK on second data byte
    cur_req = "R7"; clear_all(); s0 = stops;
    wq = '{8'h10, 8'h20, 8'h30}; run_write(7'h40, 1'b0, 2);
    chk("R7", "frames left", exp_q.size(), 0);
    chk("R7", "dnak status", {24'd0, status}, 8'h04);
    chk("R7", "valid kept", {31'd0, cmd_valid}, 1);
    chk("R7", "stop sent", stops - s0, 1);

    // R7: PEC byte NACK in write
    clear_all();
    wq = '{8'h9C}; run_write(7'h40, 1'b1, 2);
    chk("R7", "pec nak frames left", exp_q.size(), 0);
    chk("R7", "pec nak status", {24'd0, status}, 8'h04);

    // R8: arbitration lost on first address bit
    cur_req = "R8"; clear_all(); s0 = stops;
    issue(7'h7F, 1'b0, 0, 1'b0);
    while (!(scl_oe && busy)) tk(1);
    oth_sda_low = 1;
    for (int n = 0; n < 200 && !status[3]; n++) tk(1);
    chk("R8", "arb flag", {31'd0, status[3]}, 1);
    chk("R8", "released at once", {29'd0, scl_oe, sda_oe, busy}, 0);
    tk(40);
    chk("R8", "no stop", stops - s0, 0);
    chk("R8", "status only arb", {24'd0, status}, 8'h08);
    chk("R8", "valid kept", {31'd0, cmd_valid}, 1);
    oth_sda_low = 0; tk(10);

    // R9: SCL held low by the slave
    cur_req = "R9"; clear_all();
    issue(7'h21, 1'b0, 0, 1'b0);
    while (!(scl_oe && busy)) tk(1);
    slv_scl_low = 1;
    tk(200);
    chk("R9", "no timeout before limit", {31'd0, status[4]}, 0);
    tk(150);
    chk("R9", "timeout flag", {31'd0, status[4]}, 1);
    s0 = stops;
    slv_scl_low = 0;
    wait_idle();
    chk("R9", "stop after release", stops - s0, 1);
    chk("R9", "status", {24'd0, status}, 8'h10);
    chk("R9", "valid kept", {31'd0, cmd_valid}, 1);

    // R10: software stop request after first data byte is taken
    cur_req = "R10"; clear_all(); s0 = stops;
    exp_q.push_back({7'h3B, 1'b0, 1'b0});
    exp_q.push_back({8'hC3, 1'b0});
    put_tx(8'hC3);
    issue(7'h3B, 1'b0, 4, 1'b0);
    while (tx_full) tk(1);
    stop_req = 1; tk(1); stop_req = 0;
    wait_idle();
    chk("R10", "frames left", exp_q.size(), 0);
    chk("R10", "stop+complete", {24'd0, status}, 8'h41);
    chk("R10", "valid kept", {31'd0, cmd_valid}, 1);
    chk("R10", "stop sent", stops - s0, 1);

    // R11: alert during a transfer
    cur_req = "R11"; clear_all();
    fork begin tk(60); smb_alert_n = 0; tk(3); smb_alert_n = 1; end join_none
    wq = '{8'h6E}; run_write(7'h19, 1'b0, -1);
    chk("R11", "frames left", exp_q.size(), 0);
    chk("R11", "alert and complete", {24'd0, status}, 8'h81);
    chk("R11", "valid cleared", {31'd0, cmd_valid}, 0);

    // R12: write-one-to-clear per bit
    stat_clr = 8'h80; tk(1); stat_clr = 0; tk(1);
    chk("R12", "clear alert only", {24'd0, status}, 8'h01);
    stat_clr = 8'h01; tk(1); stat_clr = 0; tk(1);
    chk("R12", "clear complete", {24'd0, status}, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule